// File: doc/BRIEF.md
# DS3 AIS and Idle Defect Monitor

This block watches a received DS3 stream one M-frame at a time and decides whether the far end is sending an alarm indication signal (AIS) or an idle signal. An upstream framer supplies a strobe that marks the end of each M-frame. With that strobe it also gives a validity flag covering the M-, F- and P-bits, the three CP-bits of subframe 3, the two X-bits and an AIS-type verdict for the frame. The payload bits of the frame arrive one at a time on a serial input, each with a valid strobe.

Each condition has its own saturating up/down counter. It counts qualifying frames up and valid non-qualifying frames down. The condition is declared when the counter reaches a programmable threshold (15 is the recommended setting) and cleared when the counter drains back to zero. The defect states, together with pass-through LOS and OOF flags, appear in an 8-bit status word. Every declare or clear sets a sticky interrupt status bit, which is cleared by reading it. An active-low interrupt pin follows the enabled status bits.

Top module: `ds3_defect_monitor`

## Requirements
- R1: A valid frame counts as Idle-type only when, at the frame-end strobe, its CP-bits are 000, both X-bits are 1 and its payload matched the idle pattern. Any other valid frame is non-Idle.
- R2: The idle pattern is 1,1,0,0 repeating over the payload bits only. Its phase restarts at the first payload bit after each frame-end strobe. A payload bit presented in the frame-end cycle belongs to the frame that is ending. A single wrong bit disqualifies the frame.
- R3: The Idle counter resets to 0. It adds 1 for each Idle-type frame and subtracts 1 for each valid non-Idle frame. It saturates at 0 and at 2^CNT_W-1.
- R4: Idle is declared when the Idle counter is at or above its threshold and cleared when the counter is 0. A threshold of 0 acts as 1.
- R5: The AIS counter resets to 0. It adds 1 for each valid frame flagged AIS-type and subtracts 1 for each valid frame not flagged. It saturates at 0 and at 2^CNT_W-1.
- R6: AIS is declared when the AIS counter is at or above its threshold and cleared when the counter is 0. A threshold of 0 acts as 1.
- R7: A frame whose validity flag is low leaves both counters unchanged.
- R8: The status word has AIS in bit 7, LOS in bit 6, Idle in bit 5 and OOF in bit 4. Bits 3 to 0 read 0.
- R9: Interrupt status bit 5 is set on each AIS declare or clear, and bit 4 on each Idle declare or clear. All other bits read 0. The bits are sticky. A read strobe clears them at the next edge, but a bit that is set in that same cycle stays 1.
- R10: The interrupt pin is low exactly while some interrupt status bit is 1 and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pldBit | input | 1 | Serial payload bit |
| pldValid | input | 1 | pldBit carries a payload bit this cycle |
| frameEnd | input | 1 | One-cycle strobe closing an M-frame; the overhead inputs are sampled here |
| ohValid | input | 1 | M-, F- and P-bits of the closing frame were valid |
| cpBits | input | 3 | CP-bits of subframe 3 |
| xBits | input | 2 | X-bits of the frame |
| aisType | input | 1 | Closing frame carried the AIS signal |
| losIn | input | 1 | LOS defect from elsewhere, shown in the status word |
| oofIn | input | 1 | OOF defect from elsewhere, shown in the status word |
| idleThr | input | CNT_W | Idle declare threshold |
| aisThr | input | CNT_W | AIS declare threshold |
| intEnable | input | 8 | Per-bit enables for the interrupt pin |
| intRead | input | 1 | Read strobe that clears the interrupt status |
| statusReg | output | 8 | Status word |
| intStatus | output | 8 | Sticky interrupt status |
| intN | output | 1 | Active-low interrupt |

## Verification
The counters update at the clock edge that samples frameEnd. The defect bits in the status word and the matching interrupt status bits change one edge later, so they become visible two rising edges after frameEnd was driven. The pin follows the interrupt status bits with no further register. LOS and OOF pass straight through. A read strobe takes effect at the next edge. The bench drives inputs on falling edges and waits two full clock periods after each frame-end strobe before it compares the three outputs with its model. It tests read-clears one period after the strobe. It asserts one read strobe in the very cycle a defect changes, to check that the set wins over the clear.

// File: rtl/dfm_pkg.sv
`timescale 1ns/1ps
package dfm_pkg;
  // per-frame counter strobes from control to datapath
  typedef struct packed {
    logic idleInc;
    logic idleDec;
    logic aisInc;
    logic aisDec;
  } cntStrobe_t;

  localparam int ST_AIS  = 7;
  localparam int ST_LOS  = 6;
  localparam int ST_IDLE = 5;
  localparam int ST_OOF  = 4;
  localparam int IS_AIS  = 5;
  localparam int IS_IDLE = 4;
endpackage

// File: rtl/dfm_satcnt.sv
`timescale 1ns/1ps
module dfm_satcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (inc && !dec && cnt != MAXV) cnt <= cnt + 1'b1;
    else if (dec && !inc && cnt != '0) cnt <= cnt - 1'b1;
  end

  // no strobe, no movement (invalid frames and idle cycles)
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !dec) |=> $stable(cnt));

  // any movement must be traced to a strobe
  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != $past(cnt)) |-> ($past(inc) || $past(dec)));
endmodule

// File: rtl/dfm_datapath.sv
`timescale 1ns/1ps
module dfm_datapath
  import dfm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pldBit,
  input  logic             pldValid,
  input  logic             frameEnd,
  input  cntStrobe_t       strobe,
  output logic             patOkNow,
  output logic [CNT_W-1:0] idleCnt,
  output logic [CNT_W-1:0] aisCnt
);
  localparam int NCOND = 2;

  // idle payload pattern checker
  logic [1:0] phase;
  logic       patOk;
  logic       expBit;
  logic       bitOk;

  assign expBit   = ~phase[1];
  assign bitOk    = !pldValid || (pldBit == expBit);
  assign patOkNow = patOk && bitOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      patOk <= 1'b1;
    end else if (frameEnd) begin
      phase <= '0;
      patOk <= 1'b1;
    end else if (pldValid) begin
      phase <= phase + 2'd1;
      patOk <= patOk && bitOk;
    end
  end

  // one saturating counter per condition: index 0 idle, 1 AIS
  logic [NCOND-1:0] incV;
  logic [NCOND-1:0] decV;
  logic [CNT_W-1:0] cntV [NCOND];

  assign incV = {strobe.aisInc, strobe.idleInc};
  assign decV = {strobe.aisDec, strobe.idleDec};

  for (genvar g = 0; g < NCOND; g++) begin : gCnt
    dfm_satcnt #(.W(CNT_W)) uCnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incV[g]),
      .dec  (decV[g]),
      .cnt  (cntV[g])
    );
  end

  assign idleCnt = cntV[0];
  assign aisCnt  = cntV[1];
endmodule

// File: rtl/dfm_control.sv
`timescale 1ns/1ps
module dfm_control
  import dfm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameEnd,
  input  logic             ohValid,
  input  logic [2:0]       cpBits,
  input  logic [1:0]       xBits,
  input  logic             aisType,
  input  logic             patOkNow,
  input  logic [CNT_W-1:0] idleCnt,
  input  logic [CNT_W-1:0] aisCnt,
  input  logic [CNT_W-1:0] idleThr,
  input  logic [CNT_W-1:0] aisThr,
  input  logic             losIn,
  input  logic             oofIn,
  input  logic [7:0]       intEnable,
  input  logic             intRead,
  output cntStrobe_t       strobe,
  output logic [7:0]       statusReg,
  output logic [7:0]       intStatus,
  output logic             intN
);
  localparam int NCOND = 2;

  // frame classification
  logic idleType;
  assign idleType = ohValid && (cpBits == 3'b000) && (xBits == 2'b11) && patOkNow;

  always_comb begin
    strobe.idleInc = frameEnd && idleType;
    strobe.idleDec = frameEnd && ohValid && !idleType;
    strobe.aisInc  = frameEnd && ohValid && aisType;
    strobe.aisDec  = frameEnd && ohValid && !aisType;
  end

  // defect state with declare/clear hysteresis
  logic [CNT_W-1:0] cntA [NCOND];
  logic [CNT_W-1:0] thrA [NCOND];
  logic [NCOND-1:0] defect;
  logic [NCOND-1:0] setC;
  logic [NCOND-1:0] clrC;

  assign cntA[0] = idleCnt;
  assign cntA[1] = aisCnt;
  assign thrA[0] = idleThr;
  assign thrA[1] = aisThr;

  for (genvar g = 0; g < NCOND; g++) begin : gDef
    logic [CNT_W-1:0] effThr;
    assign effThr  = (thrA[g] == '0) ? CNT_W'(1) : thrA[g];
    assign setC[g] = !defect[g] && (cntA[g] >= effThr);
    assign clrC[g] = defect[g] && (cntA[g] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) defect <= '0;
    else       defect <= (defect | setC) & ~clrC;
  end

  // sticky change flags, cleared on read; a new set wins
  logic [7:0] setBits;
  always_comb begin
    setBits          = '0;
    setBits[IS_AIS]  = setC[1] || clrC[1];
    setBits[IS_IDLE] = setC[0] || clrC[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStatus <= '0;
    else       intStatus <= (intRead ? 8'h00 : intStatus) | setBits;
  end

  assign intN = ~|(intStatus & intEnable);

  always_comb begin
    statusReg          = '0;
    statusReg[ST_AIS]  = defect[1];
    statusReg[ST_LOS]  = losIn;
    statusReg[ST_IDLE] = defect[0];
    statusReg[ST_OOF]  = oofIn;
  end

  assert_declare_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(defect[0]) |-> ($past(idleCnt) >= $past(idleThr) && $past(idleCnt) != '0));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(defect[1]) |-> ($past(aisCnt) == '0));

  assert_aischg_R9: assert property (@(posedge clk) disable iff (!rstN)
    (defect[1] != $past(defect[1])) |-> intStatus[IS_AIS]);

  assert_idlechg_R9: assert property (@(posedge clk) disable iff (!rstN)
    (defect[0] != $past(defect[0])) |-> intStatus[IS_IDLE]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[IS_IDLE] && !intRead) |=> intStatus[IS_IDLE]);

  assert_pin_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(intStatus & intEnable)) |-> !intN);
endmodule

// File: rtl/ds3_defect_monitor.sv
`timescale 1ns/1ps
module ds3_defect_monitor
  import dfm_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pldBit,
  input  logic             pldValid,
  input  logic             frameEnd,
  input  logic             ohValid,
  input  logic [2:0]       cpBits,
  input  logic [1:0]       xBits,
  input  logic             aisType,
  input  logic             losIn,
  input  logic             oofIn,
  input  logic [CNT_W-1:0] idleThr,
  input  logic [CNT_W-1:0] aisThr,
  input  logic [7:0]       intEnable,
  input  logic             intRead,
  output logic [7:0]       statusReg,
  output logic [7:0]       intStatus,
  output logic             intN
);
  cntStrobe_t       strobe;
  logic             patOkNow;
  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] aisCnt;

  dfm_datapath #(.CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pldBit   (pldBit),
    .pldValid (pldValid),
    .frameEnd (frameEnd),
    .strobe   (strobe),
    .patOkNow (patOkNow),
    .idleCnt  (idleCnt),
    .aisCnt   (aisCnt)
  );

  dfm_control #(.CNT_W(CNT_W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .frameEnd  (frameEnd),
    .ohValid   (ohValid),
    .cpBits    (cpBits),
    .xBits     (xBits),
    .aisType   (aisType),
    .patOkNow  (patOkNow),
    .idleCnt   (idleCnt),
    .aisCnt    (aisCnt),
    .idleThr   (idleThr),
    .aisThr    (aisThr),
    .losIn     (losIn),
    .oofIn     (oofIn),
    .intEnable (intEnable),
    .intRead   (intRead),
    .strobe    (strobe),
    .statusReg (statusReg),
    .intStatus (intStatus),
    .intN      (intN)
  );
endmodule

// File: tb/sim_ds3_defect_monitor.sv
`timescale 1ns/1ps
module sim_ds3_defect_monitor;
  localparam int CNT_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pldBit = 1'b0;
  logic             pldValid = 1'b0;
  logic             frameEnd = 1'b0;
  logic             ohValid = 1'b0;
  logic [2:0]       cpBits = '0;
  logic [1:0]       xBits = '0;
  logic             aisType = 1'b0;
  logic             losIn = 1'b0;
  logic             oofIn = 1'b0;
  logic [CNT_W-1:0] idleThr = CNT_W'(15);
  logic [CNT_W-1:0] aisThr = CNT_W'(15);
  logic [7:0]       intEnable = 8'hFF;
  logic             intRead = 1'b0;
  logic [7:0]       statusReg;
  logic [7:0]       intStatus;
  logic             intN;

  always #4 clk = ~clk;

  ds3_defect_monitor #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .pldBit(pldBit), .pldValid(pldValid),
    .frameEnd(frameEnd), .ohValid(ohValid), .cpBits(cpBits), .xBits(xBits),
    .aisType(aisType), .losIn(losIn), .oofIn(oofIn), .idleThr(idleThr),
    .aisThr(aisThr), .intEnable(intEnable), .intRead(intRead),
    .statusReg(statusReg), .intStatus(intStatus), .intN(intN)
  );

  int checks = 0;
  int fails  = 0;

  // bench model: index 0 idle, 1 AIS
  int         mCnt [2];
  bit         mDef [2];
  logic [7:0] mInt;
  int         mThr [2];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int effThr(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic evalDef();
    for (int c = 0; c < 2; c++) begin
      if (!mDef[c] && mCnt[c] >= effThr(mThr[c])) begin
        mDef[c] = 1'b1;
        mInt[(c == 0) ? 4 : 5] = 1'b1;
      end else if (mDef[c] && mCnt[c] == 0) begin
        mDef[c] = 1'b0;
        mInt[(c == 0) ? 4 : 5] = 1'b1;
      end
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {mDef[1], losIn, mDef[0], oofIn, 4'b0000};
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " R4 R6 R8 status"}, statusReg, expStatus());
    chk({tag, " R9 intStatus"}, intStatus, mInt);
    chk({tag, " R10 intN"}, {7'b0, intN}, {7'b0, ~|(mInt & intEnable)});
  endtask

  function automatic int bump(input int v, input bit up);
    if (up) return (v < MAXC) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic setThr(input int ti, input int ta);
    idleThr = CNT_W'(ti);
    aisThr  = CNT_W'(ta);
    mThr[0] = ti;
    mThr[1] = ta;
    @(negedge clk);
    @(negedge clk);
    evalDef();
    checkAll("threshold change");
  endtask

  // one M-frame; badIdx < 0 means a clean idle payload
  task automatic sendFrame(input bit ov, input logic [2:0] cp, input logic [1:0] x,
                           input bit ais, input int nBits, input int badIdx,
                           input bit doRead, input string tag);
    bit patOk;
    losIn = 1'($urandom_range(0, 1));
    oofIn = 1'($urandom_range(0, 1));
    for (int i = 0; i < nBits; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        pldValid = 1'b0;
        @(negedge clk);
      end
      pldValid = 1'b1;
      pldBit   = ((i % 4) < 2) ^ (i == badIdx);
      @(negedge clk);
    end
    pldValid = 1'b0;
    frameEnd = 1'b1;
    ohValid  = ov;
    cpBits   = cp;
    xBits    = x;
    aisType  = ais;
    @(negedge clk);
    frameEnd = 1'b0;
    if (doRead) intRead = 1'b1;
    @(negedge clk);
    intRead = 1'b0;
    patOk = (badIdx < 0) || (badIdx >= nBits);
    if (ov) begin
      mCnt[0] = bump(mCnt[0], (cp == 3'b000) && (x == 2'b11) && patOk);
      mCnt[1] = bump(mCnt[1], ais);
    end
    if (doRead) mInt = 8'h00;
    evalDef();
    checkAll(tag);
  endtask

  task automatic readClear();
    chk("R9 value before read", intStatus, mInt);
    intRead = 1'b1;
    @(negedge clk);
    intRead = 1'b0;
    mInt = 8'h00;
    checkAll("R9 after read-clear");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    mCnt[0] = 0; mCnt[1] = 0;
    mDef[0] = 0; mDef[1] = 0;
    mThr[0] = 15; mThr[1] = 15;
    mInt = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset status", statusReg, 8'h00);
    chk("R9 reset intStatus", intStatus, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R8 R10 after reset");

    // qualification with threshold 1 so each verdict is visible
    setThr(1, 15);
    sendFrame(1, 3'b000, 2'b11, 0, 10, 5, 0, "R2 payload mismatch");
    sendFrame(1, 3'b010, 2'b11, 0, 8, -1, 0, "R1 CP-bits nonzero");
    sendFrame(1, 3'b000, 2'b01, 0, 8, -1, 0, "R1 X-bit zero");
    sendFrame(0, 3'b000, 2'b11, 0, 8, -1, 0, "R7 invalid frame");
    sendFrame(1, 3'b000, 2'b11, 0, 6, -1, 0, "R1 idle frame declares");
    sendFrame(1, 3'b000, 2'b11, 0, 9, -1, 0, "R2 phase relock");
    readClear();
    sendFrame(1, 3'b001, 2'b11, 0, 4, -1, 0, "R3 decrement");
    sendFrame(1, 3'b001, 2'b11, 0, 4, -1, 0, "R4 clear at zero");
    sendFrame(1, 3'b001, 2'b11, 0, 4, -1, 0, "R3 saturate at zero");
    setThr(0, 15);
    sendFrame(1, 3'b000, 2'b11, 0, 4, -1, 0, "R4 threshold zero acts as one");
    readClear();

    // AIS counter saturates high then drains
    setThr(15, 15);
    for (int i = 0; i < 70; i++)
      sendFrame(1, 3'b001, 2'b11, 1, 1, -1, 0, "R5 R6 AIS fill");
    sendFrame(0, 3'b001, 2'b11, 0, 1, -1, 0, "R7 invalid during AIS");
    for (int i = 0; i < MAXC; i++)
      sendFrame(1, 3'b001, 2'b11, 0, 1, -1, 0, "R5 R6 AIS drain from max");

    // read strobe in the cycle of a new change: set wins
    setThr(1, 15);
    sendFrame(1, 3'b000, 2'b11, 0, 4, -1, 1, "R9 set wins over read");
    readClear();

    // constrained random phase
    setThr(int'($urandom_range(1, 5)), int'($urandom_range(1, 5)));
    intEnable = 8'($urandom_range(0, 255));
    for (int f = 0; f < 300; f++) begin
      bit       ov  = ($urandom_range(0, 7) != 0);
      logic [2:0] cp = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      logic [1:0] x  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) : 2'b11;
      bit       ais = 1'($urandom_range(0, 1));
      int       nb  = int'($urandom_range(0, 12));
      int       bad = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 12)) : -1;
      bit       rd  = ($urandom_range(0, 9) == 0);
      sendFrame(ov, cp, x, ais, nb, bad, rd, "random R1 R2 R3 R5 R7");
      if (f % 50 == 49) begin
        intEnable = 8'($urandom_range(0, 255));
        @(negedge clk);
        checkAll("R10 enable change");
      end
      if (f % 20 == 19) readClear();
    end

    summary();
    $finish;
  end
endmodule